// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter Stage

This block is one stage of a synchronous binary counter. It counts up or down by one on each rising clock edge. A parallel value can be forced into it at any moment, with no clock edge needed. An asynchronous clear drives the count to zero, and it works the same way.

The stage has an active-low count-enable input and an active-low terminal-count output. To build a wider counter, tie the terminal output of one stage to the enable input of the next and give every stage the same clock. The chained stages then act as one counter, which wraps in both directions. Bit 0 of each stage is its least significant bit. The lowest stage holds the least significant bits of the whole counter.

Top module: `updown_stage`

## Requirements
- R1: While `clr` is high, `count` is 0 at once, with no clock edge needed, and it stays 0 across clock edges.
- R2: While `load_en` is high and `clr` is low, `count` equals `load_val` at once, and clock edges do not change it.
- R3: When `clr` and `load_en` are both high, `clr` wins and `count` is 0.
- R4: With no override active, `up` high and `cin_n` low, each rising clock edge adds one to `count`.
- R5: With no override active, `up` low and `cin_n` low, each rising clock edge subtracts one from `count`.
- R6: Counting up from the all-ones value gives 0. Counting down from 0 gives the all-ones value (15 for the default width of 4).
- R7: While `cin_n` is high, clock edges leave `count` unchanged.
- R8: `cout_n` is low exactly when `cin_n` is low and `count` is at its terminal value. The terminal value is all-ones when `up` is high and 0 when `up` is low. `cout_n` follows its inputs combinationally.
- R9: When `clr` or `load_en` is released before a rising clock edge, that edge counts normally from the forced value.
- R10: Two stages on one clock, with the lower stage's `cout_n` driving the upper stage's `cin_n`, count as one 8-bit counter in both directions and wrap at 255/0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock, rising edge active |
| clr | input | 1 | Asynchronous clear, active high |
| load_en | input | 1 | Asynchronous, level-sensitive preset enable, active high |
| load_val | input | WIDTH | Value forced into the counter while `load_en` is high |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| cin_n | input | 1 | Count enable from the previous stage, active low |
| count | output | WIDTH | Current count, bit 0 least significant |
| cout_n | output | 1 | Terminal-count / enable to the next stage, active low |

## Verification
An asynchronous override (clear or preset) and a clocked count step can fall into the same clock period. The bench provokes this by asserting `clr` or `load_en` half a period before an edge and releasing it 0.5 ns before that edge. It then checks that the edge steps once from the forced value, no more and no less. A second overlap is between terminal detection and the step that wraps. The bench judges it in the two-stage cascade, where the upper stage must advance on the same edge at which the lower stage wraps. The cascade is compared against an 8-bit reference count over more than a full cycle in each direction.

// File: rtl/udc_pkg.sv
// Package udc_pkg
// Shared types for the up/down counter stage.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package udc_pkg;
    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;
endpackage

// File: rtl/udc_step.sv
// Module udc_step
// Pure combinational step logic. It computes the value after one step in the
// selected direction and flags whether the current value is the terminal
// value for that direction.
// Assumes: wrap-around modulo 2**WIDTH is the intended behaviour.
module udc_step
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  dir_e             dir,
    output logic [WIDTH-1:0] nxt,
    output logic             at_end
);
    localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
    localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};

    // Next value and terminal flag for the chosen direction
    always_comb begin
        if (dir == DIR_UP) begin
            nxt    = cur + ONE;
            at_end = (cur == LAST);
        end else begin
            nxt    = cur - ONE;
            at_end = (cur == '0);
        end
    end
endmodule

// File: rtl/udc_force.sv
// Module udc_force
// Merges the clear and preset requests into one override request and the
// value to be forced. Clear has priority over preset.
// Assumes: both requests are active high and level sensitive.
module udc_force #(
    parameter int WIDTH = 4
) (
    input  logic             clr,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    output logic             ovr,
    output logic [WIDTH-1:0] ovr_val
);
    // Override request and the value it forces, clear first
    always_comb begin
        ovr     = clr | load_en;
        ovr_val = clr ? '0 : load_val;
    end
endmodule

// File: rtl/udc_core.sv
// Module udc_core
// State register of the stage. The rising edge of the override request loads
// the forced value asynchronously. While the override is held, clock edges
// reload it. Otherwise an enabled clock edge takes the next value.
// Assumes: the forced value is steady while the override is high.
module udc_core #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             ovr,
    input  logic [WIDTH-1:0] ovr_val,
    input  logic             step_en,
    input  logic             dir_up,
    input  logic [WIDTH-1:0] nxt,
    output logic [WIDTH-1:0] st
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic ovr_mark;

    // Count register with asynchronous override load
    always_ff @(posedge clk or posedge ovr) begin
        if (ovr) begin
            st <= ovr_val;
        end else if (step_en) begin
            st <= nxt;
        end
    end

    // Marks a clock period in which an override was seen (used by checks)
    always_ff @(posedge clk or posedge ovr) begin
        if (ovr) begin
            ovr_mark <= 1'b1;
        end else begin
            ovr_mark <= 1'b0;
        end
    end

    // R4 R6
    up_step_chk: assert property (@(posedge clk) disable iff (ovr)
        (step_en && dir_up) |=> (ovr_mark || st == $past(st) + ONE));

    // R5 R6
    down_step_chk: assert property (@(posedge clk) disable iff (ovr)
        (step_en && !dir_up) |=> (ovr_mark || st == $past(st) - ONE));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (ovr)
        (!step_en) |=> (ovr_mark || $stable(st)));
endmodule

// File: rtl/updown_stage.sv
// Module updown_stage
// One cascadable stage of a synchronous up/down binary counter. It has an
// asynchronous clear, an asynchronous level-sensitive preset, an active-low
// count enable and an active-low terminal-count output for chaining.
// Assumes: every chained stage shares clk; load_val is steady while load_en is high.
module updown_stage
    import udc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             up,
    input  logic             cin_n,
    output logic [WIDTH-1:0] count,
    output logic             cout_n
);
    localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};

    logic             ovr;
    logic [WIDTH-1:0] ovr_val;
    logic [WIDTH-1:0] st;
    logic [WIDTH-1:0] nxt;
    logic             at_end;
    logic             step_en;
    dir_e             dir;

    // Direction and enable decode
    always_comb begin
        dir     = dir_e'(up);
        step_en = ~cin_n;
    end

    udc_force #(.WIDTH(WIDTH)) u_force (
        .clr      (clr),
        .load_en  (load_en),
        .load_val (load_val),
        .ovr      (ovr),
        .ovr_val  (ovr_val)
    );

    udc_step #(.WIDTH(WIDTH)) u_step (
        .cur    (count),
        .dir    (dir),
        .nxt    (nxt),
        .at_end (at_end)
    );

    udc_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .ovr     (ovr),
        .ovr_val (ovr_val),
        .step_en (step_en),
        .dir_up  (up),
        .nxt     (nxt),
        .st      (st)
    );

    // Visible count: override is transparent, otherwise the register
    always_comb begin
        count  = ovr ? ovr_val : st;
        cout_n = ~(step_en & at_end);
    end

    // R1
    clear_zero_chk: assert property (@(posedge clk)
        clr |-> (count == '0));

    // R2 R3
    load_value_chk: assert property (@(posedge clk)
        (load_en && !clr) |-> (count == load_val));

    // R8
    carry_cause_chk: assert property (@(posedge clk)
        (!cout_n) |-> (!cin_n && (up ? (count == LAST) : (count == '0))));

    // R8
    carry_block_chk: assert property (@(posedge clk)
        cin_n |-> cout_n);
endmodule

// File: tb/tb_updown_stage.sv
`timescale 1ns/1ps
module tb_updown_stage;
    logic       clk = 1'b0;
    logic       clr = 1'b1;
    logic       load_en = 1'b0;
    logic [3:0] load_val = 4'h0;
    logic [3:0] hi_val = 4'h0;
    logic       up = 1'b1;
    logic       cin_n = 1'b0;
    logic [3:0] count, hi_count;
    logic       lo_cout, hi_cout;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    updown_stage #(.WIDTH(4)) dut (
        .clk(clk), .clr(clr), .load_en(load_en), .load_val(load_val),
        .up(up), .cin_n(cin_n), .count(count), .cout_n(lo_cout)
    );

    updown_stage #(.WIDTH(4)) dut_hi (
        .clk(clk), .clr(clr), .load_en(load_en), .load_val(hi_val),
        .up(up), .cin_n(lo_cout), .count(hi_count), .cout_n(hi_cout)
    );

    // Vector: {load, up, cin_n, val[3:0], exp_count[3:0], exp_cout_n}
    localparam int NV = 14;
    localparam logic [11:0] VEC [NV] = '{
        12'b1_1_0_1110_1110_1,
        12'b0_1_0_0000_1111_0,
        12'b0_1_0_0000_0000_1,
        12'b0_0_0_0000_1111_1,
        12'b0_0_0_0000_1110_1,
        12'b1_0_0_0001_0001_1,
        12'b0_0_0_0000_0000_0,
        12'b0_0_0_0000_1111_1,
        12'b0_1_1_0000_1111_1,
        12'b0_0_1_0000_1111_1,
        12'b1_1_1_0000_0000_1,
        12'b0_1_0_0000_0001_1,
        12'b1_1_0_1001_1001_1,
        12'b0_1_0_0000_1010_1
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] ref_v;
        int errs;
        logic [7:0] bad_a, bad_e;

        // R1: reset state
        #1;
        chk("R1 reset count", {4'h0, count}, 8'h00);
        chk("R8 reset cout_n", {7'h0, lo_cout}, 8'h01);
        @(negedge clk);
        @(posedge clk); #1;
        chk("R1 clear holds over edge", {4'h0, count}, 8'h00);
        @(negedge clk) clr = 1'b0;

        // Table walk: R2 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_en  = VEC[i][11];
            up       = VEC[i][10];
            cin_n    = VEC[i][9];
            load_val = VEC[i][8:5];
            @(posedge clk); #1;
            chk(VEC[i][11] ? "R2 table" : (VEC[i][9] ? "R7 table" : "R4/R5/R6 table"),
                {4'h0, count}, {4'h0, VEC[i][4:1]});
            chk("R8 table cout_n", {7'h0, lo_cout}, {7'h0, VEC[i][0]});
        end
        @(negedge clk) load_en = 1'b0;

        // R2: preset takes effect with no clock edge
        @(negedge clk);
        cin_n = 1'b1; load_val = 4'h7; load_en = 1'b1;
        #1;
        chk("R2 immediate preset", {4'h0, count}, 8'h07);
        // R3: clear wins over preset
        clr = 1'b1; #0.5;
        chk("R3 clear over preset", {4'h0, count}, 8'h00);
        clr = 1'b0; #0.5;
        chk("R2 preset after clear drops", {4'h0, count}, 8'h07);
        load_en = 1'b0;

        // R8: combinational carry at terminal value
        @(negedge clk);
        load_val = 4'hF; load_en = 1'b1; up = 1'b1; cin_n = 1'b0;
        #0.5;
        chk("R8 cout_n low at 15 up", {7'h0, lo_cout}, 8'h00);
        cin_n = 1'b1; #0.5;
        chk("R8 cout_n blocked by cin_n", {7'h0, lo_cout}, 8'h01);
        cin_n = 1'b0; up = 1'b0; #0.5;
        chk("R8 cout_n high at 15 down", {7'h0, lo_cout}, 8'h01);
        load_en = 1'b0;

        // R9: preset released just before the edge
        @(negedge clk);
        load_val = 4'h5; load_en = 1'b1; up = 1'b1; cin_n = 1'b0;
        #2.0 load_en = 1'b0;
        @(posedge clk); #1;
        chk("R9 preset release then count", {4'h0, count}, 8'h06);

        // R9: clear released just before the edge
        @(negedge clk);
        clr = 1'b1;
        #2.0 clr = 1'b0;
        @(posedge clk); #1;
        chk("R9 clear release then count", {4'h0, count}, 8'h01);

        // R10: cascade counting up
        @(negedge clk); clr = 1'b1; up = 1'b1; cin_n = 1'b0;
        @(negedge clk); clr = 1'b0;
        ref_v = 8'h00; errs = 0; bad_a = 8'h00; bad_e = 8'h00;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); #1;
            ref_v = ref_v + 8'd1;
            if ({hi_count, count} !== ref_v || hi_cout !== (ref_v != 8'hFF)) begin
                if (errs == 0) begin bad_a = {hi_count, count}; bad_e = ref_v; end
                errs++;
            end
        end
        chk("R10 cascade up", (errs == 0) ? ref_v : bad_a, (errs == 0) ? ref_v : bad_e);

        // R10: cascade counting down from a preset
        @(negedge clk); load_val = 4'h5; hi_val = 4'h0; load_en = 1'b1; up = 1'b0;
        @(negedge clk); load_en = 1'b0;
        ref_v = 8'h05; errs = 0;
        for (int k = 0; k < 300; k++) begin
            @(posedge clk); #1;
            ref_v = ref_v - 8'd1;
            if ({hi_count, count} !== ref_v || hi_cout !== (ref_v != 8'h00)) begin
                if (errs == 0) begin bad_a = {hi_count, count}; bad_e = ref_v; end
                errs++;
            end
        end
        chk("R10 cascade down", (errs == 0) ? ref_v : bad_a, (errs == 0) ? ref_v : bad_e);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule